// File: doc/BRIEF.md
# AXI-Stream Random Stall Injector

This block is a pass-through stage for an AXI4-Stream link, placed between a producer and a consumer under test. Each beat (data plus the end-of-packet flag) that enters the slave side leaves the master side unchanged and in the same order. Only the timing changes. Storage is a registered two-entry skid buffer, so the slave-side ready comes straight from a flop and the master side can stall without losing data.

When throttling is enabled, a 16-bit pseudo-random sequence generator masks the slave-side ready and the master-side valid. The upstream block then sees irregular back-pressure and the downstream block sees irregular bubbles, which exercises their handshake handling. A master-side beat that is already on the bus is never withdrawn. The generator only delays the moment a new beat is shown. The seed is a parameter, so each seed gives a different stall pattern. With throttling disabled, the block is a plain two-entry skid buffer.

Top module: `axis_stall_injector`

## Requirements
- R1: Every beat accepted on the slave side (s_valid and s_ready high at a rising edge) leaves the master side with identical data and last flag, in acceptance order, with no beat lost or duplicated.
- R2: The block holds at most two beats. s_ready is high only while fewer than two beats are held.
- R3: Once m_valid is high while m_ready is low, m_valid stays high at the next edge and m_data and m_last do not change.
- R4: With THROTTLE_EN = 0, s_ready is high exactly when fewer than two beats are held, and m_valid is high exactly when at least one beat is held.
- R5: With THROTTLE_EN = 1, there are cycles where a beat is held but m_valid is low, and cycles where fewer than two beats are held but s_ready is low.
- R6: The stall sequence comes from a 16-bit Fibonacci shift register with feedback taps 16, 14, 13 and 11. It advances on every clock after reset. A seed of zero is replaced by 0x0001, so traffic keeps flowing with that seed.
- R7: Two throttled instances with different seeds, given identical stimulus after reset, produce different s_ready/m_valid patterns.
- R8: An active-low reset empties both entries, holds m_valid low and reloads the sequence from the seed. After identical stimulus following two resets, the s_ready/m_valid pattern repeats exactly.
- R9: s_ready and m_valid depend only on registered state. A change of m_ready within a cycle does not change them until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Slave-side beat valid |
| s_ready | output | 1 | Slave-side ready (registered, optionally masked) |
| s_data | input | DATA_W | Slave-side beat data |
| s_last | input | 1 | Slave-side end-of-packet flag |
| m_valid | output | 1 | Master-side beat valid (optionally delayed) |
| m_ready | input | 1 | Master-side ready from the consumer |
| m_data | output | DATA_W | Master-side beat data |
| m_last | output | 1 | Master-side end-of-packet flag |

## Verification
The hardest state to reach from the ports is a full buffer while the generator withholds a shown beat. This needs a beat held in the skid entry, a pending master beat and a low m_ready all at the same time, with throttling active. The stimulus reaches it with a phase of heavy offering and rare consumer ready, followed by a phase of sparse offering and mostly-ready draining. A behavioural queue model checks ordering, occupancy and hold rules on every cycle. Repeatability and seed dependence are tested by running fixed all-ready windows right after reset and comparing pattern signatures.

// File: rtl/stall_pkg.sv
package stall_pkg;
  localparam int LFSR_W = 16;
  typedef logic [LFSR_W-1:0] lfsr_t;
  // feedback taps 16,14,13,11 expressed as bit positions 15,13,12,10
  localparam lfsr_t TAP_MASK = 16'hB400;
  localparam lfsr_t SEED_FALLBACK = 16'h0001;
  localparam int READY_GATE_BIT = 4;
  localparam int VALID_GATE_BIT = 11;
endpackage

// File: rtl/stall_lfsr.sv
module stall_lfsr
  import stall_pkg::*;
#(
  parameter lfsr_t SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  output logic gate_ready,
  output logic gate_valid,
  output logic alive
);
  localparam lfsr_t SEED_EFF = (SEED == '0) ? SEED_FALLBACK : SEED;

  lfsr_t state_q, state_d;
  logic  feedback;

  always_comb begin
    feedback = ^(state_q & TAP_MASK);
    state_d  = {state_q[LFSR_W-2:0], feedback};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED_EFF;
    else        state_q <= state_d;
  end

  assign gate_ready = state_q[READY_GATE_BIT];
  assign gate_valid = state_q[VALID_GATE_BIT];
  assign alive      = |state_q;
endmodule

// File: rtl/stall_skid.sv
module stall_skid #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] in_beat,
  output logic         head_valid,
  output logic [W-1:0] head_beat,
  output logic         room,
  output logic         skid_valid
);
  logic         head_v_q, head_v_d, skid_v_q, skid_v_d;
  logic         head_en, skid_en, head_from_skid;
  logic [W-1:0] head_q, skid_q, head_d;
  logic         head_free;

  always_comb begin
    head_free      = !head_v_q || pop;
    head_v_d       = head_v_q;
    skid_v_d       = skid_v_q;
    head_en        = 1'b0;
    skid_en        = 1'b0;
    head_from_skid = 1'b0;
    if (head_free) begin
      if (skid_v_q) begin
        head_en        = 1'b1;
        head_from_skid = 1'b1;
        head_v_d       = 1'b1;
        skid_v_d       = 1'b0;
      end else if (push) begin
        head_en  = 1'b1;
        head_v_d = 1'b1;
      end else begin
        head_v_d = 1'b0;
      end
    end else if (push) begin
      skid_en  = 1'b1;
      skid_v_d = 1'b1;
    end
    head_d = head_from_skid ? skid_q : in_beat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_v_q <= 1'b0;
      skid_v_q <= 1'b0;
    end else begin
      head_v_q <= head_v_d;
      skid_v_q <= skid_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (head_en) head_q <= head_d;
    if (skid_en) skid_q <= in_beat;
  end

  assign head_valid = head_v_q;
  assign head_beat  = head_q;
  assign room       = !skid_v_q;
  assign skid_valid = skid_v_q;
endmodule

// File: rtl/stall_gate.sv
module stall_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_ready,
  input  logic gate_valid,
  input  logic room,
  input  logic head_valid,
  input  logic s_valid,
  input  logic m_ready,
  output logic s_ready,
  output logic m_valid,
  output logic push,
  output logic pop
);
  logic shown_q, shown_d;

  always_comb begin
    m_valid = head_valid && (shown_q || gate_valid);
    s_ready = room && gate_ready;
    push    = s_valid && s_ready;
    pop     = m_valid && m_ready;
    shown_d = m_valid && !m_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shown_q <= 1'b0;
    else        shown_q <= shown_d;
  end
endmodule

// File: rtl/axis_stall_injector.sv
module axis_stall_injector
  import stall_pkg::*;
#(
  parameter int    DATA_W      = 32,
  parameter lfsr_t SEED        = 16'hACE1,
  parameter bit    THROTTLE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last
);
  localparam int BEAT_W = DATA_W + 1;

  logic              gate_ready, gate_valid, lfsr_alive;
  logic              room, head_valid, skid_valid, push, pop;
  logic [BEAT_W-1:0] head_beat;

  generate
    if (THROTTLE_EN) begin : g_throttle
      stall_lfsr #(.SEED(SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n),
        .gate_ready(gate_ready), .gate_valid(gate_valid), .alive(lfsr_alive)
      );
    end else begin : g_plain
      assign gate_ready = 1'b1;
      assign gate_valid = 1'b1;
      assign lfsr_alive = 1'b1;
    end
  endgenerate

  stall_gate u_gate (
    .clk(clk), .rst_n(rst_n),
    .gate_ready(gate_ready), .gate_valid(gate_valid),
    .room(room), .head_valid(head_valid),
    .s_valid(s_valid), .m_ready(m_ready),
    .s_ready(s_ready), .m_valid(m_valid),
    .push(push), .pop(pop)
  );

  stall_skid #(.W(BEAT_W)) u_skid (
    .clk(clk), .rst_n(rst_n),
    .push(push), .pop(pop),
    .in_beat({s_last, s_data}),
    .head_valid(head_valid), .head_beat(head_beat),
    .room(room), .skid_valid(skid_valid)
  );

  assign m_data = head_beat[DATA_W-1:0];
  assign m_last = head_beat[DATA_W];
endmodule

// File: rtl/stall_checker.sv
module stall_checker #(
  parameter int DATA_W      = 32,
  parameter bit THROTTLE_EN = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              m_last,
  input logic              head_valid,
  input logic              skid_valid,
  input logic              lfsr_alive
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  assert_valid_has_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> head_valid);

  assert_skid_behind_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
    skid_valid |-> head_valid);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    skid_valid |-> !s_ready);

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && head_valid && !(m_valid && m_ready)) |=> skid_valid);

  assert_no_lockup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_alive);

  assert_plain_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!THROTTLE_EN && head_valid) |-> m_valid);
endmodule

bind axis_stall_injector stall_checker #(.DATA_W(DATA_W), .THROTTLE_EN(THROTTLE_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
  .head_valid(head_valid), .skid_valid(skid_valid), .lfsr_alive(lfsr_alive)
);

// File: tb/test_axis_stall_injector.sv
`timescale 1ns/1ps
module stall_ref #(
  parameter int DATA_W = 32,
  parameter bit EXACT  = 1'b0,
  parameter string TAG = "x"
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              offer,
  input  logic              take,
  input  logic              s_ready,
  input  logic              m_valid,
  input  logic [DATA_W-1:0] m_data,
  input  logic              m_last,
  output logic              s_valid,
  output logic [DATA_W-1:0] s_data,
  output logic              s_last,
  output logic              m_ready,
  output int                checks,
  output int                errors,
  output int                stalls,
  output int                gaps,
  output int                rcvd,
  output int                depth,
  output logic [31:0]       sig
);
  logic [DATA_W:0] q[$];
  logic [DATA_W:0] held_beat;
  logic held, acc;
  int cnt;

  assign m_ready = take;

  initial begin
    checks = 0; errors = 0; stalls = 0; gaps = 0; rcvd = 0; depth = 0;
    sig = '0; held = 0; acc = 0; cnt = 0; held_beat = '0;
    s_valid = 0; s_data = '0; s_last = 0;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      q.delete();
      s_valid = 0; held = 0; acc = 0;
    end else begin
      checks++;
      if (m_valid && (q.size() == 0 || {m_last, m_data} != q[0])) begin
        errors++;
        $display("FAIL R1 %s: out beat %h expected %h (held %0d)", TAG, {m_last, m_data},
                 (q.size() > 0) ? q[0] : '0, q.size());
      end
      if (s_ready && q.size() >= 2) begin
        errors++;
        $display("FAIL R2 %s: s_ready=%0b with %0d held, expected 0", TAG, s_ready, q.size());
      end
      if (held && (!m_valid || {m_last, m_data} != held_beat)) begin
        errors++;
        $display("FAIL R3 %s: valid=%0b beat=%h expected valid=1 beat=%h", TAG, m_valid,
                 {m_last, m_data}, held_beat);
      end
      if (EXACT) begin
        if (s_ready != (q.size() < 2) || m_valid != (q.size() > 0)) begin
          errors++;
          $display("FAIL R4 %s: s_ready=%0b m_valid=%0b expected %0b %0b", TAG, s_ready,
                   m_valid, q.size() < 2, q.size() > 0);
        end
      end
      if (q.size() > 0 && !m_valid) stalls++;
      if (q.size() < 2 && !s_ready) gaps++;
      sig = {sig[29:0], s_ready, m_valid};
      // source: retire the beat accepted at the previous edge, then maybe offer
      if (acc) begin s_valid = 0; acc = 0; end
      if (!s_valid && offer) begin
        s_valid = 1;
        s_data  = DATA_W'(cnt * 32'h9E37 + 7);
        s_last  = (cnt % 5) == 4;
      end
      if (s_valid && s_ready) begin
        q.push_back({s_last, s_data});
        cnt++;
        acc = 1;
      end
      if (m_valid && take) begin
        void'(q.pop_front());
        rcvd++;
        held = 0;
      end else if (m_valid) begin
        held = 1;
        held_beat = {m_last, m_data};
      end else begin
        held = 0;
      end
    end
    depth = q.size();
  end
endmodule

module test_axis_stall_injector;
  localparam int DATA_W = 32;
  logic clk = 0;
  logic rst_n = 0;
  logic offer = 0, take = 0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  logic sv_a, sr_a, mv_a, ml_a, sl_a, mr_a;
  logic [DATA_W-1:0] sd_a, md_a;
  logic sv_b, sr_b, mv_b, ml_b, sl_b, mr_b;
  logic [DATA_W-1:0] sd_b, md_b;
  logic sv_c, sr_c, mv_c, ml_c, sl_c, mr_c;
  logic [DATA_W-1:0] sd_c, md_c;
  int ck_a, er_a, st_a, gp_a, rc_a, dp_a;
  int ck_b, er_b, st_b, gp_b, rc_b, dp_b;
  int ck_c, er_c, st_c, gp_c, rc_c, dp_c;
  logic [31:0] sig_a, sig_b, sig_c;

  // seed zero: must fall back to a nonzero start
  axis_stall_injector #(.DATA_W(DATA_W), .SEED(16'h0000), .THROTTLE_EN(1'b1)) i_axis_stall_injector (
    .clk(clk), .rst_n(rst_n), .s_valid(sv_a), .s_ready(sr_a), .s_data(sd_a), .s_last(sl_a),
    .m_valid(mv_a), .m_ready(mr_a), .m_data(md_a), .m_last(ml_a));
  stall_ref #(.DATA_W(DATA_W), .EXACT(1'b0), .TAG("seed0")) u_ref_a (
    .clk(clk), .rst_n(rst_n), .offer(offer), .take(take), .s_ready(sr_a), .m_valid(mv_a),
    .m_data(md_a), .m_last(ml_a), .s_valid(sv_a), .s_data(sd_a), .s_last(sl_a), .m_ready(mr_a),
    .checks(ck_a), .errors(er_a), .stalls(st_a), .gaps(gp_a), .rcvd(rc_a), .depth(dp_a), .sig(sig_a));

  axis_stall_injector #(.DATA_W(DATA_W), .SEED(16'hBEEF), .THROTTLE_EN(1'b1)) i_axis_stall_injector_b (
    .clk(clk), .rst_n(rst_n), .s_valid(sv_b), .s_ready(sr_b), .s_data(sd_b), .s_last(sl_b),
    .m_valid(mv_b), .m_ready(mr_b), .m_data(md_b), .m_last(ml_b));
  stall_ref #(.DATA_W(DATA_W), .EXACT(1'b0), .TAG("seedB")) u_ref_b (
    .clk(clk), .rst_n(rst_n), .offer(offer), .take(take), .s_ready(sr_b), .m_valid(mv_b),
    .m_data(md_b), .m_last(ml_b), .s_valid(sv_b), .s_data(sd_b), .s_last(sl_b), .m_ready(mr_b),
    .checks(ck_b), .errors(er_b), .stalls(st_b), .gaps(gp_b), .rcvd(rc_b), .depth(dp_b), .sig(sig_b));

  axis_stall_injector #(.DATA_W(DATA_W), .SEED(16'h1234), .THROTTLE_EN(1'b0)) i_axis_stall_injector_c (
    .clk(clk), .rst_n(rst_n), .s_valid(sv_c), .s_ready(sr_c), .s_data(sd_c), .s_last(sl_c),
    .m_valid(mv_c), .m_ready(mr_c), .m_data(md_c), .m_last(ml_c));
  stall_ref #(.DATA_W(DATA_W), .EXACT(1'b1), .TAG("plain")) u_ref_c (
    .clk(clk), .rst_n(rst_n), .offer(offer), .take(take), .s_ready(sr_c), .m_valid(mv_c),
    .m_data(md_c), .m_last(ml_c), .s_valid(sv_c), .s_data(sd_c), .s_last(sl_c), .m_ready(mr_c),
    .checks(ck_c), .errors(er_c), .stalls(st_c), .gaps(gp_c), .rcvd(rc_c), .depth(dp_c), .sig(sig_c));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input int n, input int p_offer, input int p_take);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      offer = ($urandom % 100) < p_offer;
      take  = ($urandom % 100) < p_take;
    end
  endtask

  task automatic do_reset(output logic [31:0] wa, output logic [31:0] wb);
    @(posedge clk); #1;
    rst_n = 0; offer = 1; take = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!mv_a && !mv_b && !mv_c, "R8", "m_valid during reset", {mv_a, mv_b, mv_c}, 0);
    @(posedge clk); #1;
    rst_n = 1;
    run(16, 100, 100);
    @(negedge clk); #0.1;
    wa = sig_a; wb = sig_b;
  endtask

  task automatic comb_probe();
    for (int i = 0; i < 20; i++) begin
      logic r0, v0, r1, v1;
      @(posedge clk); #1;
      offer = ($urandom % 100) < 60;
      take  = ($urandom % 100) < 50;
      r0 = sr_a; v0 = mv_a;
      take = ~take; #0.5;
      r1 = sr_a; v1 = mv_a;
      take = ~take;
      check(r0 == r1 && v0 == v1, "R9", "s_ready/m_valid change with m_ready", {r1, v1}, {r0, v0});
    end
  endtask

  logic [31:0] wa0, wb0, wa1, wb1;
  int rc_before;

  initial begin
    fork
      begin
        do_reset(wa0, wb0);
        run(3000, 50, 50);
        run(1000, 90, 20);   // fill: skid entry held while consumer stalls
        run(1000, 20, 90);
        comb_probe();
        run(1000, 95, 70);
        // reset with beats in flight
        run(10, 100, 0);
        do_reset(wa1, wb1);
        check(wa1 == wa0, "R8", "pattern after second reset (seed0)", wa1, wa0);
        check(wb1 == wb0, "R8", "pattern after second reset (seedB)", wb1, wb0);
        check(wa0 != wb0, "R7", "seed patterns equal", wa0, wb0 ^ 1);
        rc_before = rc_a;
        run(2000, 60, 60);
        check(rc_a - rc_before > 300, "R6", "seed-zero beats delivered", rc_a - rc_before, 301);
        run(300, 0, 100);
        @(negedge clk); #0.1;
        check(dp_a == 0 && dp_b == 0 && dp_c == 0, "R1", "beats left after drain",
              dp_a + dp_b + dp_c, 0);
        check(st_a > 0 && st_b > 0, "R5", "output bubbles with beat held", st_a, 1);
        check(gp_a > 0 && gp_b > 0, "R5", "ready gaps with room", gp_a, 1);
        check(st_c == 0 && gp_c == 0, "R4", "plain instance stalls", st_c + gp_c, 0);
        check(rc_c > 1000 && rc_b > 1000, "R1", "beats delivered", rc_c, 1001);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      end
    join_any
    disable fork;
    checks = checks + ck_a + ck_b + ck_c;
    errors = errors + er_a + er_b + er_c;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule